// File: doc/BRIEF.md
# Register-Mapped MDIO Management Master

This block is a management-bus master for Ethernet PHYs. A processor programs it through four 32-bit registers on a simple synchronous port that has a valid strobe, a write flag, a byte address and write data, and returns read data in the same cycle. The master divides the system clock down to produce MDC. It serializes frames on a split MDIO pin (output, output enable, input) that the pad ring ties to the shared open-drain line.

Two framing modes are supported. In the short mode a frame carries a PHY address and a register number. In the extended mode a frame carries a PHY address and a device address, and the 16-bit register address goes out in an address frame of its own. A data write launches a write frame, and setting the read bit in the control register launches a read frame. Software polls a bus-busy flag in the status register and a transaction-busy flag in bit 31 of the data register. A read that no PHY answers sets a read-error flag and returns all ones.

Register offsets: 0x0 status/configuration, 0x4 control, 0x8 data, 0xC address.

Top module: `mdio_reg_master`

## Requirements
- R1: After reset the status register reads 0x0000_0400 (half-divider 4, short mode, not busy, no error). The control, data and address registers read 0. MDC is low and the MDIO output enable is low.
- R2: MDC is low while the bus is idle. During a frame its period is 2*max(D,1) system clocks, where D is the half-divider in status bits 15:8.
- R3: With status bit 6 clear, a write to the data register launches a frame of 32 ones, then start 01, opcode 01, port address (control bits 9:5, MSB first), register number (control bits 4:0), turnaround 10 and the 16 data bits, MSB first. Data bit 31 reads 1 until the frame ends.
- R4: When control bit 10 is set, the 32-bit preamble is omitted and the frame begins at the start code.
- R5: Writing the control register with bit 15 set launches a read frame with opcode 10 in short mode. The master releases MDIO from the first turnaround bit to the end of the frame, samples 16 data bits MSB first, and places them in data bits 15:0.
- R6: If the PHY does not hold the second turnaround bit low during a read, status bit 1 is set and data bits 15:0 read 0xFFFF. A later read that is answered clears status bit 1.
- R7: With status bit 6 set, a write to the address register launches an address frame: start 00, opcode 00, port, device address, turnaround 10 and the 16-bit address. Status bit 0 stays 1 until that frame ends, and data bit 31 stays 0.
- R8: With status bit 6 set, data and read frames use start code 00, with opcode 01 for a write and 11 for a read.
- R9: While status bit 0 is 1, writes to any register are ignored: no register value changes and no new frame starts.
- R10: With status bit 6 clear, a write to the address register stores the value but launches no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Register access strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| req_rdata | output | 32 | Read data, valid in the cycle of a read access |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO line value as seen at the pad |

## Verification
The assertions assume that software leaves the configuration alone during a frame. They also assume that the line the master samples during a read turnaround is driven only by the PHY, so the output enable is low whenever the block is idle. The bench therefore launches every transaction from an idle bus, except in the scenario that deliberately writes while busy. Its PHY responder drives the line only between the turnaround and the last data bit, changing it just after an MDC rising edge, and the bench resolves the line as pulled high whenever neither side drives it.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int PRE_BITS   = 32;
  localparam int FRAME_BITS = 64;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam int TA_FIRST   = PRE_BITS + 14;
  localparam int TA_LAST    = PRE_BITS + 15;

  localparam logic [1:0] OFS_STAT = 2'd0;
  localparam logic [1:0] OFS_CTRL = 2'd1;
  localparam logic [1:0] OFS_DATA = 2'd2;
  localparam logic [1:0] OFS_ADDR = 2'd3;

  typedef enum logic [1:0] {FR_ADDR = 2'd0, FR_WRITE = 2'd1, FR_READ = 2'd2} frame_kind_e;

  function automatic logic [31:0] frame_word(input frame_kind_e kind, input logic ext,
                                             input logic [4:0] port, input logic [4:0] dev,
                                             input logic [15:0] payload);
    logic [1:0] st;
    logic [1:0] op;
    st = ext ? 2'b00 : 2'b01;
    case (kind)
      FR_ADDR:  op = 2'b00;
      FR_WRITE: op = 2'b01;
      default:  op = ext ? 2'b11 : 2'b10;
    endcase
    return {st, op, port, dev, 2'b10, payload};
  endfunction
endpackage

// File: rtl/mdm_clkgen.sv
module mdm_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] half_div,
  output logic             mdc,
  output logic             rise_tick,
  output logic             fall_tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d, lim;
  logic             mdc_q, mdc_d, wrap;

  assign lim  = (half_div == '0) ? DIV_W'(1) : half_div;
  assign wrap = (cnt_q == lim - DIV_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!en) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (wrap) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end else begin
      cnt_d = cnt_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc       = mdc_q;
  assign rise_tick = en & wrap & ~mdc_q;
  assign fall_tick = en & wrap & mdc_q;
endmodule

// File: rtl/mdm_framer.sv
module mdm_framer
  import mdm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        launch,
  input  frame_kind_e kind,
  input  logic        ext,
  input  logic        skip_pre,
  input  logic [4:0]  port,
  input  logic [4:0]  dev,
  input  logic [15:0] payload,
  input  logic        rise_tick,
  input  logic        fall_tick,
  input  logic        mdio_i,
  output logic        active,
  output frame_kind_e act_kind,
  output logic        done,
  output logic        ta_bad,
  output logic [15:0] rd_bits,
  output logic        mdio_o,
  output logic        mdio_oe
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

  logic             act_q, act_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [31:0]      word_q, word_d;
  frame_kind_e      kind_q, kind_d;
  logic             bad_q, bad_d;
  logic [15:0]      cap_q, cap_d;
  logic             in_pre, released;

  always_comb begin
    act_d  = act_q;
    idx_d  = idx_q;
    word_d = word_q;
    kind_d = kind_q;
    bad_d  = bad_q;
    cap_d  = cap_q;
    if (!act_q) begin
      if (launch) begin
        act_d  = 1'b1;
        idx_d  = skip_pre ? IDX_W'(PRE_BITS) : '0;
        word_d = frame_word(kind, ext, port, dev, payload);
        kind_d = kind;
        bad_d  = 1'b0;
      end
    end else begin
      if (rise_tick && kind_q == FR_READ) begin
        if (idx_q == IDX_W'(TA_LAST)) bad_d = mdio_i;
        else if (idx_q > IDX_W'(TA_LAST)) cap_d = {cap_q[14:0], mdio_i};
      end
      if (fall_tick) begin
        if (idx_q == LAST_IDX) act_d = 1'b0;
        else idx_d = idx_q + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      idx_q  <= '0;
      word_q <= '0;
      kind_q <= FR_ADDR;
      bad_q  <= 1'b0;
      cap_q  <= '0;
    end else begin
      act_q  <= act_d;
      idx_q  <= idx_d;
      word_q <= word_d;
      kind_q <= kind_d;
      bad_q  <= bad_d;
      cap_q  <= cap_d;
    end
  end

  assign in_pre   = (idx_q < IDX_W'(PRE_BITS));
  assign released = (kind_q == FR_READ) && (idx_q >= IDX_W'(TA_FIRST));
  assign mdio_o   = act_q & (in_pre | word_q[~idx_q[4:0]]);
  assign mdio_oe  = act_q & ~released;
  assign active   = act_q;
  assign act_kind = kind_q;
  assign done     = act_q & fall_tick & (idx_q == LAST_IDX);
  assign ta_bad   = bad_q;
  assign rd_bits  = cap_q;
endmodule

// File: rtl/mdio_reg_master.sv
module mdio_reg_master
  import mdm_pkg::*;
#(
  parameter int          DIV_W        = 8,
  parameter int          SYNC_STAGES  = 2,
  parameter logic [7:0]  HALF_DIV_RST = 8'd4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [3:0]  req_addr,
  input  logic [31:0] req_wdata,
  output logic [31:0] req_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe[SYNC_STAGES-1];

  logic [DIV_W-1:0] cfg_div_q, cfg_div_d;
  logic             cfg_ext_q, cfg_ext_d;
  logic [4:0]       ctl_dev_q, ctl_dev_d, ctl_port_q, ctl_port_d;
  logic             ctl_nopre_q, ctl_nopre_d;
  logic [15:0]      data_q, data_d, addr_q, addr_d;
  logic             rd_err_q, rd_err_d;

  logic             fr_active, fr_done, fr_ta_bad, rise_tick, fall_tick;
  frame_kind_e      fr_kind, ln_kind;
  logic [15:0]      fr_rd_bits, ln_payload;
  logic [4:0]       ln_port, ln_dev;
  logic             ln_nopre, launch, wr_ok;
  logic [1:0]       sel;

  assign sel   = req_addr[3:2];
  assign wr_ok = req_valid & req_write & ~fr_active;

  always_comb begin
    cfg_div_d   = cfg_div_q;
    cfg_ext_d   = cfg_ext_q;
    ctl_dev_d   = ctl_dev_q;
    ctl_port_d  = ctl_port_q;
    ctl_nopre_d = ctl_nopre_q;
    data_d      = data_q;
    addr_d      = addr_q;
    rd_err_d    = rd_err_q;
    launch      = 1'b0;
    ln_kind     = FR_WRITE;
    ln_payload  = req_wdata[15:0];
    ln_port     = ctl_port_q;
    ln_dev      = ctl_dev_q;
    ln_nopre    = ctl_nopre_q;
    if (wr_ok) begin
      case (sel)
        OFS_STAT: begin
          cfg_div_d = req_wdata[8 +: DIV_W];
          cfg_ext_d = req_wdata[6];
        end
        OFS_CTRL: begin
          ctl_dev_d   = req_wdata[4:0];
          ctl_port_d  = req_wdata[9:5];
          ctl_nopre_d = req_wdata[10];
          if (req_wdata[15]) begin
            launch     = 1'b1;
            ln_kind    = FR_READ;
            ln_payload = '0;
            ln_port    = req_wdata[9:5];
            ln_dev     = req_wdata[4:0];
            ln_nopre   = req_wdata[10];
            rd_err_d   = 1'b0;
          end
        end
        OFS_DATA: begin
          data_d = req_wdata[15:0];
          launch = 1'b1;
        end
        default: begin
          addr_d = req_wdata[15:0];
          if (cfg_ext_q) begin
            launch  = 1'b1;
            ln_kind = FR_ADDR;
          end
        end
      endcase
    end
    if (fr_done && fr_kind == FR_READ) begin
      rd_err_d = fr_ta_bad;
      data_d   = fr_ta_bad ? 16'hFFFF : fr_rd_bits;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cfg_div_q   <= DIV_W'(HALF_DIV_RST);
      cfg_ext_q   <= 1'b0;
      ctl_dev_q   <= '0;
      ctl_port_q  <= '0;
      ctl_nopre_q <= 1'b0;
      data_q      <= '0;
      addr_q      <= '0;
      rd_err_q    <= 1'b0;
    end else begin
      cfg_div_q   <= cfg_div_d;
      cfg_ext_q   <= cfg_ext_d;
      ctl_dev_q   <= ctl_dev_d;
      ctl_port_q  <= ctl_port_d;
      ctl_nopre_q <= ctl_nopre_d;
      data_q      <= data_d;
      addr_q      <= addr_d;
      rd_err_q    <= rd_err_d;
    end
  end

  always_comb begin
    req_rdata = '0;
    if (req_valid && !req_write) begin
      case (sel)
        OFS_STAT: req_rdata = {16'b0, 8'(cfg_div_q), 1'b0, cfg_ext_q, 4'b0, rd_err_q, fr_active};
        OFS_CTRL: req_rdata = {16'b0, 5'b0, ctl_nopre_q, ctl_port_q, ctl_dev_q};
        OFS_DATA: req_rdata = {fr_active && fr_kind != FR_ADDR, 15'b0, data_q};
        default:  req_rdata = {16'b0, addr_q};
      endcase
    end
  end

  mdm_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_int_n), .en(fr_active), .half_div(cfg_div_q),
    .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdm_framer u_frm (
    .clk(clk), .rst_n(rst_int_n), .launch(launch), .kind(ln_kind), .ext(cfg_ext_q),
    .skip_pre(ln_nopre), .port(ln_port), .dev(ln_dev), .payload(ln_payload),
    .rise_tick(rise_tick), .fall_tick(fall_tick), .mdio_i(mdio_i),
    .active(fr_active), .act_kind(fr_kind), .done(fr_done), .ta_bad(fr_ta_bad),
    .rd_bits(fr_rd_bits), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );
endmodule

// File: rtl/mdm_checker.sv
module mdm_checker
  import mdm_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input frame_kind_e      kind,
  input logic             mdc,
  input logic             mdio_oe,
  input logic             rd_err,
  input logic [15:0]      data,
  input logic [DIV_W-1:0] div,
  input logic             ext
);
  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);

  assert_mdc_idle_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  assert_error_all_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_err) |-> data == 16'hFFFF);

  assert_cfg_frozen_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable({div, ext}));

  assert_addr_frame_ext_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && kind == FR_ADDR) |-> ext);

  assert_mdc_only_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> busy);
endmodule

bind mdio_reg_master mdm_checker #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(fr_active), .kind(fr_kind), .mdc(mdc),
  .mdio_oe(mdio_oe), .rd_err(rd_err_q), .data(data_q), .div(cfg_div_q), .ext(cfg_ext_q)
);

// File: tb/mdio_reg_master_test.sv
module mdio_reg_master_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [3:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] req_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_line;

  int checks = 0;
  int fails = 0;

  logic        phy_en = 1'b0;
  logic        phy_bit = 1'b1;
  logic        resp_on = 1'b0;
  logic [15:0] resp_val = '0;
  logic [63:0] cap = '0;
  int          rise_n = 0;
  int          base_idx = 0;
  int          clk_cnt = 0;
  int          last_rise = 0;
  int          period = 0;

  always #5 clk = ~clk;

  assign mdio_line = mdio_oe ? mdio_o : (phy_en ? phy_bit : 1'b1);

  mdio_reg_master uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_rdata(req_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_line)
  );

  always @(posedge clk) clk_cnt++;

  always @(posedge mdc) begin
    int idx_now;
    int nxt;
    idx_now   = base_idx + rise_n;
    cap       = {cap[62:0], mdio_line};
    rise_n++;
    period    = clk_cnt - last_rise;
    last_rise = clk_cnt;
    nxt       = idx_now + 1;
    if (resp_on && nxt >= 47 && nxt <= 63) begin
      phy_en  <= 1'b1;
      phy_bit <= (nxt == 47) ? 1'b0 : resp_val[63 - nxt];
    end else begin
      phy_en  <= 1'b0;
    end
  end

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic reg_wr(input logic [3:0] a, input logic [31:0] v);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = v;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic reg_rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    #1 v = req_rdata;
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 20000; i++) begin
      reg_rd(4'h0, s);
      if (s[0] == 1'b0) break;
    end
  endtask

  task automatic arm(input int base);
    cap = '0; rise_n = 0; base_idx = base;
  endtask

  function automatic logic [31:0] fw(input logic [1:0] st, input logic [1:0] op,
                                     input logic [4:0] p, input logic [4:0] d,
                                     input logic [15:0] v);
    return {st, op, p, d, 2'b10, v};
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    reg_rd(4'h0, v); check("R1 status", v, 32'h0000_0400);
    reg_rd(4'h4, v); check("R1 control", v, 0);
    reg_rd(4'h8, v); check("R1 data", v, 0);
    reg_rd(4'hC, v); check("R1 address", v, 0);
    check("R1 mdc/oe", {mdc, mdio_oe}, 0);
  endtask

  task automatic t_c22_write();
    logic [31:0] v;
    reg_wr(4'h0, 32'h0000_0200);
    reg_wr(4'h4, (32'd3 << 5) | 32'd5);
    arm(0);
    reg_wr(4'h8, 32'h0000_A5C3);
    reg_rd(4'h8, v); check("R3 data busy", v[31], 1);
    wait_idle();
    check("R3 bit count", rise_n, 64);
    check("R3 frame", cap, {32'hFFFF_FFFF, fw(2'b01, 2'b01, 5'd3, 5'd5, 16'hA5C3)});
    check("R2 period div2", period, 4);
    reg_rd(4'h8, v); check("R3 data idle", v, 32'h0000_A5C3);
    check("R2 mdc idle", mdc, 0);
  endtask

  task automatic t_div_edges();
    reg_wr(4'h0, 32'h0000_0300);
    arm(32);
    reg_wr(4'h4, 32'h400 | (32'd1 << 5) | 32'd2);
    reg_wr(4'h8, 32'h0000_0F0F);
    wait_idle();
    check("R2 period div3", period, 6);
    check("R4 bit count", rise_n, 32);
    check("R4 frame", cap[31:0], fw(2'b01, 2'b01, 5'd1, 5'd2, 16'h0F0F));
    reg_wr(4'h0, 32'h0000_0000);
    arm(32);
    reg_wr(4'h8, 32'h0000_00FF);
    wait_idle();
    check("R2 period div0", period, 2);
    check("R4 frame div0", cap[31:0], fw(2'b01, 2'b01, 5'd1, 5'd2, 16'h00FF));
  endtask

  task automatic t_c22_read();
    logic [31:0] v;
    reg_wr(4'h0, 32'h0000_0200);
    resp_on = 1'b1; resp_val = 16'h1234;
    arm(0);
    reg_wr(4'h4, 32'h8000 | (32'd7 << 5) | 32'd9);
    reg_rd(4'h8, v); check("R5 data busy", v[31], 1);
    wait_idle();
    check("R5 frame", cap, {32'hFFFF_FFFF, fw(2'b01, 2'b10, 5'd7, 5'd9, 16'h1234)});
    reg_rd(4'h8, v); check("R5 read value", v, 32'h0000_1234);
    reg_rd(4'h0, v); check("R5 no error", v[1], 0);
    resp_on = 1'b0;
  endtask

  task automatic t_no_answer();
    logic [31:0] v;
    resp_on = 1'b0;
    arm(0);
    reg_wr(4'h4, 32'h8000 | (32'd4 << 5) | 32'd1);
    wait_idle();
    reg_rd(4'h0, v); check("R6 error set", v[1], 1);
    reg_rd(4'h8, v); check("R6 all ones", v, 32'h0000_FFFF);
    resp_on = 1'b1; resp_val = 16'h8001;
    arm(0);
    reg_wr(4'h4, 32'h8000 | (32'd4 << 5) | 32'd1);
    wait_idle();
    reg_rd(4'h0, v); check("R6 error cleared", v[1], 0);
    reg_rd(4'h8, v); check("R6 later value", v, 32'h0000_8001);
    resp_on = 1'b0;
  endtask

  task automatic t_ext();
    logic [31:0] v;
    reg_wr(4'h0, 32'h0000_0240);
    reg_wr(4'h4, (32'd2 << 5) | 32'd30);
    arm(0);
    reg_wr(4'hC, 32'h0000_0ABC);
    reg_rd(4'h0, v); check("R7 bus busy", v[0], 1);
    reg_rd(4'h8, v); check("R7 no data busy", v[31], 0);
    wait_idle();
    check("R7 address frame", cap, {32'hFFFF_FFFF, fw(2'b00, 2'b00, 5'd2, 5'd30, 16'h0ABC)});
    arm(0);
    reg_wr(4'h8, 32'h0000_5555);
    wait_idle();
    check("R8 write frame", cap, {32'hFFFF_FFFF, fw(2'b00, 2'b01, 5'd2, 5'd30, 16'h5555)});
    resp_on = 1'b1; resp_val = 16'hC3A0;
    arm(0);
    reg_wr(4'h4, 32'h8000 | (32'd2 << 5) | 32'd30);
    wait_idle();
    check("R8 read frame", cap, {32'hFFFF_FFFF, fw(2'b00, 2'b11, 5'd2, 5'd30, 16'hC3A0)});
    reg_rd(4'h8, v); check("R8 read value", v, 32'h0000_C3A0);
    resp_on = 1'b0;
    reg_wr(4'h0, 32'h0000_0200);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] v;
    reg_wr(4'h4, (32'd6 << 5) | 32'd3);
    reg_wr(4'hC, 32'h0000_0777);
    reg_rd(4'h0, v); check("R10 no frame", v[0], 0);
    reg_rd(4'hC, v); check("R10 stored", v, 32'h0000_0777);
    arm(0);
    reg_wr(4'h8, 32'h0000_2468);
    reg_wr(4'h8, 32'h0000_1111);
    reg_wr(4'h4, 32'h0000_83FF);
    reg_wr(4'hC, 32'h0000_2222);
    reg_wr(4'h0, 32'h0000_0040);
    wait_idle();
    check("R9 single frame", rise_n, 64);
    check("R9 frame", cap, {32'hFFFF_FFFF, fw(2'b01, 2'b01, 5'd6, 5'd3, 16'h2468)});
    reg_rd(4'h8, v); check("R9 data kept", v, 32'h0000_2468);
    reg_rd(4'h4, v); check("R9 control kept", v, (32'd6 << 5) | 32'd3);
    reg_rd(4'hC, v); check("R9 address kept", v, 32'h0000_0777);
    reg_rd(4'h0, v); check("R9 config kept", v, 32'h0000_0200);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #23 rst_n = 1'b1;
    repeat (5) @(posedge clk);
    t_reset();
    t_c22_write();
    t_div_edges();
    t_c22_read();
    t_no_answer();
    t_ext();
    t_busy_ignore();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule